// File: doc/BRIEF.md
# Real-Time Clock Periodic Interrupt and Flag Register

This block produces the programmable periodic event and the square-wave output of a real-time clock, both derived from a 32.768 kHz tick. The tick reaches the block as a one-cycle enable pulse in the system clock domain. A 4-bit rate code selects the periodic rate, and each step of the code halves the frequency. The same divider chain feeds a square-wave pin, which toggles twice per periodic interval.

The block also holds the interrupt flag byte. This byte collects three kinds of event. Periodic events come from the internal divider. Alarm events and update-ended events arrive as single-cycle pulses from the timekeeping logic outside the block. A source flag latches whenever its event occurs, whether or not that source is enabled. The summary bit, and the active-high interrupt request that follows it, count only the enabled sources. A read of the flag byte returns its contents and clears it in the same access. An event that coincides with the read is kept for the next read.

The rate code and the control byte are driven from the register file outside the block.

Top module: `rtc_periodic_irq`

## Requirements
- R1: After reset the flag byte reads 0x00, and the interrupt request and square-wave output are low.
- R2: Rate code 0 produces no periodic flag (bit 6) and holds the square-wave output low.
- R3: For rate codes 2 to 15, periodic events occur every 2^(code-1) ticks. Code 2 gives 16384 Hz and code 15 gives 2 Hz.
- R4: Rate code 1 gives the same 2-tick period as code 2.
- R5: When control bit 3 is set and the rate code is non-zero, the square-wave output has a period equal to the periodic interval and is high for half of it. When control bit 3 is clear, the output stays low.
- R6: The flag byte holds the periodic flag in bit 6, the alarm flag in bit 5 and the update-ended flag in bit 4. Each flag sets on its event whatever the control enables are.
- R7: Flag-byte bit 7 is set exactly when some source flag is set and its enable is set. The enables are control bit 6 for periodic, bit 5 for alarm and bit 4 for update-ended. The interrupt request output equals bit 7.
- R8: A read strobe returns the current flag byte and clears all flags from the next cycle.
- R9: An event that arrives in the same cycle as a read sets its flag after the read.
- R10: Flag-byte bits 3:0 always read 0.
- R11: A set flag stays set until a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_32k | input | 1 | One-cycle pulse per 32.768 kHz reference tick |
| rate_sel | input | 4 | Periodic rate code (0 = off) |
| ctl_byte | input | 8 | Control byte: bit 6 periodic enable, bit 5 alarm enable, bit 4 update enable, bit 3 square-wave enable |
| rd_flags | input | 1 | Read strobe for the flag byte (clears it) |
| alarm_evt | input | 1 | Alarm event pulse |
| update_evt | input | 1 | Update-ended event pulse |
| flag_byte | output | 8 | Current flag byte: {summary, periodic, alarm, update, 4'b0} |
| irq | output | 1 | Active-high interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
The periodic divider is driven with the tick held high, while the flag byte is read every cycle. The bench measures the distance between successive periodic flags for codes 1, 2, 3, 6 and 15. This separates an off-by-one in the code-to-shift mapping from a missing clamp of code 1, and the code 15 run exercises the top bit of the divider. The square wave is timed for rising-edge spacing and high time at two codes, which shows a wrong tap bit or a wrong duty cycle. For the flags, the bench tries events with all enables off, then turns the enables on afterwards, then fires an event in the same cycle as a read. These cases separate latching from gating and show whether a colliding event is lost.

// File: rtl/rtc_pi_pkg.sv
package rtc_pi_pkg;
    // control byte bit positions (decoded by the register file neighbour)
    localparam int CTL_PIE_BIT  = 6;
    localparam int CTL_AIE_BIT  = 5;
    localparam int CTL_UIE_BIT  = 4;
    localparam int CTL_SQWE_BIT = 3;

    // flag byte bit positions
    localparam int FLG_SUM_BIT = 7;
    localparam int FLG_PER_BIT = 6;
    localparam int FLG_ALM_BIT = 5;
    localparam int FLG_UPD_BIT = 4;

    typedef struct packed {
        logic per;
        logic alm;
        logic upd;
    } src_flags_t;

    // divider width needed for a given rate-code width
    function automatic int div_width(input int rate_w);
        return (1 << rate_w) - 2;
    endfunction
endpackage

// File: rtl/rtc_pi_divider.sv
module rtc_pi_divider
    import rtc_pi_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] rate,
    input  logic              sqw_en,
    output logic              per_evt,
    output logic              sqw
);
    localparam int CNT_W = div_width(RATE_W);
    localparam int SH_W  = $clog2(CNT_W + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sqw;
    } div_state_t;

    div_state_t       st_d, st_q;
    logic [SH_W-1:0]  shift_d;
    logic [SH_W-1:0]  tap_d;
    logic [CNT_W-1:0] mask_d;
    logic             active_d;

    always_comb begin
        active_d = (rate != '0);
        // codes 0 and 1 share the shortest interval
        shift_d  = (rate <= RATE_W'(1)) ? SH_W'(1) : SH_W'(rate - RATE_W'(1));
        tap_d    = shift_d - SH_W'(1);
        mask_d   = {CNT_W{1'b1}} >> (CNT_W - int'(shift_d));
        per_evt  = tick && active_d && ((st_q.cnt & mask_d) == mask_d);

        st_d     = st_q;
        if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
        st_d.sqw = sqw_en && active_d && st_d.cnt[tap_d];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sqw = st_q.sqw;

    p_rate_off_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == '0) |-> !per_evt);
    p_rate_off_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate == '0) |=> !sqw);
    p_evt_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |-> tick);
    p_sqw_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !sqw_en |=> !sqw);
endmodule

// File: rtl/rtc_pi_flags.sv
module rtc_pi_flags
    import rtc_pi_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rd,
    input  src_flags_t evt,
    input  src_flags_t en,
    output logic [7:0] rdata,
    output logic       irq
);
    src_flags_t fl_d, fl_q;
    logic       sum_d;

    always_comb begin
        // a read clears, but an event in the same cycle survives it
        if (rd) begin
            fl_d = evt;
        end else begin
            fl_d = fl_q | evt;
        end
        sum_d = (fl_q.per & en.per) | (fl_q.alm & en.alm) | (fl_q.upd & en.upd);

        rdata              = '0;
        rdata[FLG_SUM_BIT] = sum_d;
        rdata[FLG_PER_BIT] = fl_q.per;
        rdata[FLG_ALM_BIT] = fl_q.alm;
        rdata[FLG_UPD_BIT] = fl_q.upd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign irq = sum_d;

    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (evt == '0)) |=> (rdata == 8'h00));
    p_collide_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        evt.alm |=> rdata[FLG_ALM_BIT]);
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd && rdata[FLG_UPD_BIT]) |=> rdata[FLG_UPD_BIT]);
    p_low_nibble_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[3:0] == 4'h0);
    p_irq_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rdata[6:4] != 3'b000));
endmodule

// File: rtl/rtc_periodic_irq.sv
module rtc_periodic_irq
    import rtc_pi_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_32k,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic [7:0]        ctl_byte,
    input  logic              rd_flags,
    input  logic              alarm_evt,
    input  logic              update_evt,
    output logic [7:0]        flag_byte,
    output logic              irq,
    output logic              sqw
);
    logic       per_evt;
    src_flags_t evt_w, en_w;
    logic       unused_ctl;

    assign unused_ctl = ^{ctl_byte[7], ctl_byte[2:0]};

    assign evt_w = '{per: per_evt, alm: alarm_evt, upd: update_evt};
    assign en_w  = '{per: ctl_byte[CTL_PIE_BIT],
                     alm: ctl_byte[CTL_AIE_BIT],
                     upd: ctl_byte[CTL_UIE_BIT]};

    rtc_pi_divider #(.RATE_W(RATE_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_32k),
        .rate    (rate_sel),
        .sqw_en  (ctl_byte[CTL_SQWE_BIT]),
        .per_evt (per_evt),
        .sqw     (sqw)
    );

    rtc_pi_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (rd_flags),
        .evt   (evt_w),
        .en    (en_w),
        .rdata (flag_byte),
        .irq   (irq)
    );

    p_irq_is_summary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == flag_byte[FLG_SUM_BIT]);
endmodule

// File: tb/rtc_periodic_irq_tb.sv
module rtc_periodic_irq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_32k = 1'b0;
    logic [3:0] rate_sel = 4'd0;
    logic [7:0] ctl_byte = 8'h00;
    logic       rd_flags = 1'b0;
    logic       alarm_evt = 1'b0;
    logic       update_evt = 1'b0;
    logic [7:0] flag_byte;
    logic       irq;
    logic       sqw;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_periodic_irq u_dut (
        .clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .rate_sel(rate_sel),
        .ctl_byte(ctl_byte), .rd_flags(rd_flags), .alarm_evt(alarm_evt),
        .update_evt(update_evt), .flag_byte(flag_byte), .irq(irq), .sqw(sqw)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_flags();
        @(negedge clk) rd_flags = 1'b1;
        @(negedge clk) rd_flags = 1'b0;
    endtask

    task automatic t_reset();
        check(flag_byte == 8'h00, "R1 flag byte", flag_byte, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
        check(sqw == 1'b0, "R1 sqw", sqw, 0);
    endtask

    task automatic t_event_flags();
        rate_sel = 4'd0; ctl_byte = 8'h00;
        @(negedge clk) alarm_evt = 1'b1;
        @(negedge clk) alarm_evt = 1'b0;
        check(flag_byte == 8'h20, "R6 alarm latched without enable", flag_byte, 8'h20);
        check(irq == 1'b0, "R7 irq off while disabled", irq, 0);
        @(negedge clk) update_evt = 1'b1;
        @(negedge clk) update_evt = 1'b0;
        repeat (3) @(negedge clk);
        check(flag_byte == 8'h30, "R11 flags held", flag_byte, 8'h30);
        ctl_byte = 8'h20;
        #1;
        check(flag_byte == 8'hB0, "R7 summary with alarm enable", flag_byte, 8'hB0);
        check(irq == 1'b1, "R7 irq follows summary", irq, 1);
        @(negedge clk) rd_flags = 1'b1;
        #1;
        check(flag_byte == 8'hB0, "R8 read returns contents", flag_byte, 8'hB0);
        @(negedge clk) rd_flags = 1'b0;
        check(flag_byte == 8'h00, "R8 cleared after read", flag_byte, 0);
        check(irq == 1'b0, "R8 irq drops after read", irq, 0);
        ctl_byte = 8'h00;
    endtask

    task automatic t_collide();
        ctl_byte = 8'h10;
        @(negedge clk) alarm_evt = 1'b1;
        @(negedge clk) begin alarm_evt = 1'b0; rd_flags = 1'b1; update_evt = 1'b1; end
        @(negedge clk) begin rd_flags = 1'b0; update_evt = 1'b0; end
        check(flag_byte == 8'h90, "R9 event during read kept", flag_byte, 8'h90);
        clear_flags();
        ctl_byte = 8'h00;
    endtask

    task automatic t_pf_no_enable();
        ctl_byte = 8'h00; rate_sel = 4'd2;
        @(negedge clk) tick_32k = 1'b1;
        repeat (10) @(negedge clk);
        tick_32k = 1'b0;
        @(negedge clk);
        check(flag_byte == 8'h40, "R6 periodic latched without enable", flag_byte, 8'h40);
        check(irq == 1'b0, "R7 irq off for disabled periodic", irq, 0);
        ctl_byte = 8'h40;
        #1;
        check(irq == 1'b1 && flag_byte == 8'hC0, "R7 enable after event", flag_byte, 8'hC0);
        clear_flags();
        ctl_byte = 8'h00; rate_sel = 4'd0;
    endtask

    task automatic t_periodic(input int code, input int exp_period, input string tag);
        int hits[3];
        int nh = 0;
        int cyc = 0;
        bit nib_ok = 1'b1;
        ctl_byte = 8'h40; rate_sel = 4'(code);
        @(negedge clk) begin tick_32k = 1'b1; rd_flags = 1'b1; end
        while (nh < 3 && cyc < 60000) begin
            @(negedge clk);
            cyc++;
            if (flag_byte[3:0] != 4'h0) nib_ok = 1'b0;
            if (flag_byte[6]) begin
                hits[nh] = cyc;
                nh++;
            end
        end
        tick_32k = 1'b0; rd_flags = 1'b0;
        check(nh == 3, {tag, " periodic flags seen"}, nh, 3);
        if (nh == 3)
            check(hits[2] - hits[1] == exp_period, {tag, " periodic interval"},
                  hits[2] - hits[1], exp_period);
        check(nib_ok, "R10 low nibble zero", nib_ok, 1);
        clear_flags();
        ctl_byte = 8'h00; rate_sel = 4'd0;
    endtask

    task automatic t_sqw(input int code, input int period);
        int rise[2];
        int nr = 0;
        int high = 0;
        int cyc = 0;
        bit prev;
        ctl_byte = 8'h08; rate_sel = 4'(code);
        @(negedge clk) tick_32k = 1'b1;
        prev = sqw;
        while (nr < 2 && cyc < 1000) begin
            @(negedge clk);
            cyc++;
            if (sqw && !prev) begin
                rise[nr] = cyc;
                nr++;
            end
            if (sqw && nr == 1) high++;
            prev = sqw;
        end
        tick_32k = 1'b0;
        check(nr == 2, "R5 square-wave edges seen", nr, 2);
        if (nr == 2) begin
            check(rise[1] - rise[0] == period, "R5 square-wave period", rise[1] - rise[0], period);
            check(high == period / 2, "R5 square-wave high time", high, period / 2);
        end
        clear_flags();
        ctl_byte = 8'h00; rate_sel = 4'd0;
    endtask

    task automatic t_quiet();
        bit sq_seen = 1'b0;
        bit pf_seen = 1'b0;
        ctl_byte = 8'h00; rate_sel = 4'd3;
        @(negedge clk) tick_32k = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (sqw) sq_seen = 1'b1;
        end
        check(!sq_seen, "R5 square wave low when disabled", sq_seen, 0);
        clear_flags();
        ctl_byte = 8'h48; rate_sel = 4'd0; sq_seen = 1'b0;
        @(negedge clk);
        repeat (60) begin
            @(negedge clk);
            if (sqw) sq_seen = 1'b1;
            if (flag_byte[6]) pf_seen = 1'b1;
        end
        tick_32k = 1'b0;
        check(!sq_seen, "R2 square wave low at code 0", sq_seen, 0);
        check(!pf_seen, "R2 no periodic flag at code 0", pf_seen, 0);
        ctl_byte = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_event_flags();
        t_collide();
        t_pf_no_enable();
        t_periodic(1, 2, "R4 code 1");
        t_periodic(2, 2, "R3 code 2");
        t_periodic(3, 4, "R3 code 3");
        t_periodic(6, 32, "R3 code 6");
        t_periodic(15, 16384, "R3 code 15");
        t_sqw(3, 4);
        t_sqw(1, 2);
        t_quiet();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule